// File: doc/BRIEF.md
# Tree Diagnostic Test Sequencer

This block exercises a universal selector tree of `LEVELS` levels, a cellular structure whose output equals specialization bit `C[X]` for the applied select vector `X`. It drives the select vector and the `2^LEVELS`-bit specialization vector toward the tree, compares the returned tree output against the expected level, and records one error bitmap per test. A single start pulse launches the complete fault-independent diagnostic: four tests of `2^LEVELS` steps each, `2^(LEVELS+2)` applications in total. That is the minimal set for a model where any cell may turn into an arbitrary three-input function.

There are two fixed tests and two travelling tests. In a fixed test every specialization bit holds the same level. In a travelling test, only the bit selected by the current `X` differs from all the others. Each test comes in a zero polarity, where the tree output should be 0, and a one polarity, where it should be 1. The tree is healthy exactly when no bit is set in any of the four bitmaps. A pass flag reports this together with done. Interpreting the bitmaps to find faulty subtrees is left to a separate localizer.

Top module: `tds_sequencer`

## Requirements
- R1: After reset, busy, done and pass are 0, all four error bitmaps are 0, and `tree_x` and `tree_spec` are 0.
- R2: A start accepted while idle presents a new vector in each of the next `4*2^LEVELS` cycles, one vector per cycle. The first vector appears in the cycle after the start edge. The tests run in the order fixed-zero (code 0), fixed-one (code 1), travelling-zero (code 2), travelling-one (code 3). Within each test `tree_x` counts from 0 up to `2^LEVELS-1`.
- R3: During fixed-zero every bit of `tree_spec` is 0. During fixed-one every bit is 1.
- R4: During travelling-zero, bit `tree_x` of `tree_spec` is 0 and every other bit is 1. During travelling-one the pattern is the complement of that.
- R5: The expected tree output is 0 in tests 0 and 2 and 1 in tests 1 and 3. The tree output is sampled at the end of the cycle in which the vector is presented. A mismatch at select value x sets bit x of that test's bitmap (`err_fix0`, `err_fix1`, `err_trv0`, `err_trv1`). Bits, once set, stay set until the next accepted start.
- R6: busy rises on the edge that accepts start. busy falls, and done rises, exactly `4*2^LEVELS+1` edges after that edge. busy and done are never 1 together.
- R7: pass is 1 with done only when no bit is set in any of the four bitmaps; otherwise it is 0. pass is never 1 without done.
- R8: start while busy is ignored: the sequence and its timing continue unchanged.
- R9: An accepted start clears done, pass and all four bitmaps on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the diagnostic (ignored while busy) |
| tree_out | input | 1 | Output returned by the tree under test |
| busy | output | 1 | Diagnostic in progress |
| done | output | 1 | Diagnostic finished, held until the next start |
| pass | output | 1 | All four tests matched, valid with done |
| tree_x | output | LEVELS | Select vector driven to the tree |
| tree_spec | output | 2^LEVELS | Specialization vector driven to the tree |
| err_fix0 | output | 2^LEVELS | Mismatch bitmap of the fixed-zero test, bit per select value |
| err_fix1 | output | 2^LEVELS | Mismatch bitmap of the fixed-one test |
| err_trv0 | output | 2^LEVELS | Mismatch bitmap of the travelling-zero test |
| err_trv1 | output | 2^LEVELS | Mismatch bitmap of the travelling-one test |

## Verification
The hardest situation to reach is a fault that only shows in one polarity, which must set bits in exactly two bitmaps and leave the others clean. The bench puts a behavioural tree next to the block, so it can force the output at chosen select values to a stuck level or invert it. From the four bitmaps it then expects an exact split. A start pulse issued in the middle of a faulty run, followed by a clean run, checks both that a start during busy is ignored and that the error history is cleared on the next start.

// File: rtl/tds_pkg.sv
package tds_pkg;
  typedef enum logic [1:0] {
    TST_FIX0 = 2'd0,
    TST_FIX1 = 2'd1,
    TST_TRV0 = 2'd2,
    TST_TRV1 = 2'd3
  } tst_e;

  function automatic logic exp_level(input tst_e t);
    return (t == TST_FIX1) || (t == TST_TRV1);
  endfunction

  function automatic logic is_travel(input tst_e t);
    return (t == TST_TRV0) || (t == TST_TRV1);
  endfunction
endpackage

// File: rtl/tds_step_ctrl.sv
module tds_step_ctrl #(
  parameter int LEVELS = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  output logic              run_q,
  output logic              last,
  output logic [LEVELS+1:0] idx_q,
  output logic [LEVELS+1:0] idx_d
);
  localparam int IDX_W = LEVELS + 2;
  localparam logic [IDX_W-1:0] IDX_MAX = {IDX_W{1'b1}};

  logic run_d;

  assign last = (idx_q == IDX_MAX);

  always_comb begin
    idx_d = idx_q;
    run_d = run_q;
    if (accept) begin
      idx_d = '0;
      run_d = 1'b1;
    end else if (run_q) begin
      if (last) run_d = 1'b0;
      else      idx_d = idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else begin
      run_q <= run_d;
      idx_q <= idx_d;
    end
  end

  // R2: while running, the step index moves by exactly one each cycle
  p_step_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && !last) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/tds_pattern_gen.sv
module tds_pattern_gen
  import tds_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  tst_e                   test,
  input  logic [LEVELS-1:0]      sel,
  output logic [(1<<LEVELS)-1:0] spec
);
  localparam int WIDTH = 1 << LEVELS;

  logic pol;
  logic trv;
  assign pol = exp_level(test);
  assign trv = is_travel(test);

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    assign spec[j] = pol ^ (trv & (sel != LEVELS'(j)));
  end
endmodule

// File: rtl/tds_err_map.sv
module tds_err_map #(
  parameter int LEVELS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [1:0]               wr_test,
  input  logic [LEVELS-1:0]        wr_idx,
  output logic [4*(1<<LEVELS)-1:0] maps,
  output logic                     any_err
);
  localparam int WIDTH = 1 << LEVELS;

  for (genvar t = 0; t < 4; t++) begin : g_test
    logic [WIDTH-1:0] row;
    always_ff @(posedge clk) begin
      if (rst || clr) row <= '0;
      else if (wr_en && (wr_test == 2'(t))) row[wr_idx] <= 1'b1;
    end
    assign maps[t*WIDTH +: WIDTH] = row;
  end

  assign any_err = |maps;

  // R5: recorded mismatches are never lost without a clear
  p_map_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    !clr |=> ((maps & $past(maps)) == $past(maps)));
endmodule

// File: rtl/tds_sequencer.sv
module tds_sequencer
  import tds_pkg::*;
#(
  parameter int LEVELS = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   tree_out,
  output logic                   busy,
  output logic                   done,
  output logic                   pass,
  output logic [LEVELS-1:0]      tree_x,
  output logic [(1<<LEVELS)-1:0] tree_spec,
  output logic [(1<<LEVELS)-1:0] err_fix0,
  output logic [(1<<LEVELS)-1:0] err_fix1,
  output logic [(1<<LEVELS)-1:0] err_trv0,
  output logic [(1<<LEVELS)-1:0] err_trv1
);
  localparam int WIDTH = 1 << LEVELS;
  localparam int IDX_W = LEVELS + 2;

  logic             accept;
  logic             run_q;
  logic             last;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] idx_d;
  tst_e             cur_test;
  tst_e             nxt_test;
  logic [WIDTH-1:0] spec_d;

  // compare stage
  logic              cap_valid;
  logic              cap_mis;
  logic              cap_last;
  logic [1:0]        cap_test;
  logic [LEVELS-1:0] cap_x;

  logic [4*WIDTH-1:0] maps;
  logic               any_err;

  assign accept   = start && !busy;
  assign cur_test = tst_e'(idx_q[IDX_W-1:LEVELS]);
  assign nxt_test = tst_e'(idx_d[IDX_W-1:LEVELS]);
  assign tree_x   = idx_q[LEVELS-1:0];

  tds_step_ctrl #(.LEVELS(LEVELS)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .run_q  (run_q),
    .last   (last),
    .idx_q  (idx_q),
    .idx_d  (idx_d)
  );

  tds_pattern_gen #(.LEVELS(LEVELS)) u_pat (
    .test (nxt_test),
    .sel  (idx_d[LEVELS-1:0]),
    .spec (spec_d)
  );

  always_ff @(posedge clk) begin
    if (rst) tree_spec <= '0;
    else     tree_spec <= spec_d;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_valid <= 1'b0;
      cap_mis   <= 1'b0;
      cap_last  <= 1'b0;
      cap_test  <= '0;
      cap_x     <= '0;
    end else begin
      cap_valid <= run_q;
      cap_mis   <= run_q && (tree_out != exp_level(cur_test));
      cap_last  <= run_q && last;
      cap_test  <= cur_test;
      cap_x     <= tree_x;
    end
  end

  tds_err_map #(.LEVELS(LEVELS)) u_map (
    .clk     (clk),
    .rst     (rst),
    .clr     (accept),
    .wr_en   (cap_valid && cap_mis),
    .wr_test (cap_test),
    .wr_idx  (cap_x),
    .maps    (maps),
    .any_err (any_err)
  );

  assign err_fix0 = maps[0*WIDTH +: WIDTH];
  assign err_fix1 = maps[1*WIDTH +: WIDTH];
  assign err_trv0 = maps[2*WIDTH +: WIDTH];
  assign err_trv1 = maps[3*WIDTH +: WIDTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      pass <= 1'b0;
    end else if (accept) begin
      busy <= 1'b1;
      done <= 1'b0;
      pass <= 1'b0;
    end else if (cap_valid && cap_last) begin
      busy <= 1'b0;
      done <= 1'b1;
      pass <= !any_err && !cap_mis;
    end
  end

  // R6: busy and done exclude each other
  p_busy_done_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(busy && done));

  // R7: pass only alongside done
  p_pass_with_done_r7: assert property (@(posedge clk) disable iff (rst)
    pass |-> done);

  // R2: select vector climbs by one inside a test
  p_x_climb_r2: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q) && tree_x != '0) |-> (tree_x == $past(tree_x) + LEVELS'(1)));

  // R4: travelling-zero holds exactly one zero, at the selected position
  p_trv0_single_r4: assert property (@(posedge clk) disable iff (rst)
    (run_q && cur_test == TST_TRV0) |-> ($countones(~tree_spec) == 1 && !tree_spec[tree_x]));

  // R8: a start while running leaves the sequence busy
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (run_q && start) |=> busy);
endmodule

// File: tb/tds_sequencer_test.sv
module tds_sequencer_test;
  localparam int LEVELS = 3;
  localparam int WIDTH  = 1 << LEVELS;
  localparam int STEPS  = 4 * WIDTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic tree_out;
  logic busy, done, pass;
  logic [LEVELS-1:0] tree_x;
  logic [WIDTH-1:0]  tree_spec, err_fix0, err_fix1, err_trv0, err_trv1;

  int checks = 0;
  int errors = 0;

  // behavioural tree with injectable faults
  logic             stuck_on = 1'b0;
  logic [LEVELS-1:0] stuck_x = '0;
  logic             stuck_val = 1'b0;
  logic             inv_on = 1'b0;
  logic [LEVELS-1:0] inv_x = '0;

  always #4 clk = ~clk;

  always_comb begin
    tree_out = tree_spec[tree_x];
    if (stuck_on && tree_x == stuck_x) tree_out = stuck_val;
    if (inv_on && tree_x == inv_x) tree_out = ~tree_out;
  end

  tds_sequencer #(.LEVELS(LEVELS)) uut (
    .clk(clk), .rst(rst), .start(start), .tree_out(tree_out),
    .busy(busy), .done(done), .pass(pass),
    .tree_x(tree_x), .tree_spec(tree_spec),
    .err_fix0(err_fix0), .err_fix1(err_fix1),
    .err_trv0(err_trv0), .err_trv1(err_trv1)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [WIDTH-1:0] exp_spec(input int t, input int x);
    logic [WIDTH-1:0] s;
    for (int j = 0; j < WIDTH; j++)
      s[j] = t[0] ^ (t[1] & (j != x));
    return s;
  endfunction

  function automatic logic [WIDTH-1:0] exp_map(input int t);
    logic [WIDTH-1:0] m = '0;
    if (stuck_on && stuck_val != t[0]) m[stuck_x] = 1'b1;
    if (inv_on) m[inv_x] = ~m[inv_x];
    if (stuck_on && inv_on && stuck_x == inv_x && stuck_val != t[0]) m[inv_x] = 1'b0;
    if (stuck_on && inv_on && stuck_x == inv_x && stuck_val == t[0]) m[inv_x] = 1'b1;
    return m;
  endfunction

  task automatic test_reset();
    @(negedge clk);
    check(!busy && !done && !pass, "R1 flags", {busy, done, pass}, 0);
    check((err_fix0 | err_fix1 | err_trv0 | err_trv1) == '0, "R1 maps",
          err_fix0 | err_fix1 | err_trv0 | err_trv1, 0);
    check(tree_x == '0 && tree_spec == '0, "R1 vectors", {tree_x, tree_spec}, 0);
  endtask

  task automatic run_diag(input string tag, input bit poke);
    logic [WIDTH-1:0] em;
    bit any;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    for (int k = 0; k < STEPS; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == 0) begin
        check(busy && !done && !pass, "R9 flags cleared", {busy, done, pass}, 3'b100);
        check((err_fix0 | err_fix1 | err_trv0 | err_trv1) == '0, "R9 maps cleared",
              err_fix0 | err_fix1 | err_trv0 | err_trv1, 0);
      end
      check(tree_x == LEVELS'(k % WIDTH), "R2 select order", tree_x, k % WIDTH);
      if ((k / WIDTH) < 2)
        check(tree_spec == exp_spec(k / WIDTH, k % WIDTH), "R3 fixed spec", tree_spec,
              exp_spec(k / WIDTH, k % WIDTH));
      else
        check(tree_spec == exp_spec(k / WIDTH, k % WIDTH), "R4 travelling spec", tree_spec,
              exp_spec(k / WIDTH, k % WIDTH));
      if (poke && k == 10) start = 1'b1;   // R8 stimulus
    end
    @(negedge clk);
    check(busy && !done, "R6 still busy one edge before done", {busy, done}, 2'b10);
    @(negedge clk);
    check(!busy && done, "R6 done timing", {busy, done}, 2'b01);
    any = 1'b0;
    em = exp_map(0); any |= |em;
    check(err_fix0 == em, {"R5 fix0 map ", tag}, err_fix0, em);
    em = exp_map(1); any |= |em;
    check(err_fix1 == em, {"R5 fix1 map ", tag}, err_fix1, em);
    em = exp_map(2); any |= |em;
    check(err_trv0 == em, {"R5 trv0 map ", tag}, err_trv0, em);
    em = exp_map(3); any |= |em;
    check(err_trv1 == em, {"R5 trv1 map ", tag}, err_trv1, em);
    check(pass == !any, {"R7 pass ", tag}, pass, !any);
    repeat (3) @(negedge clk);
    check(done && !busy && pass == !any, "R6 done held", {busy, done, pass}, {1'b0, 1'b1, !any});
  endtask

  task automatic test_clean();
    stuck_on = 1'b0; inv_on = 1'b0;
    run_diag("clean", 1'b0);
  endtask

  task automatic test_stuck_high();
    stuck_on = 1'b1; stuck_x = 3'd5; stuck_val = 1'b1; inv_on = 1'b0;
    run_diag("stuck1", 1'b0);
  endtask

  task automatic test_mixed_with_poke();
    stuck_on = 1'b1; stuck_x = 3'd0; stuck_val = 1'b0;
    inv_on = 1'b1; inv_x = 3'd7;
    run_diag("mixed R8", 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    test_reset();
    test_clean();
    test_stuck_high();
    test_mixed_with_poke();
    test_clean();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule